// File: doc/BRIEF.md
# Zero-Crossing Frequency Load-Shed Controller

This block watches the polarity of a sampled line voltage and turns the spacing of its zero crossings into a graded load-shedding command. A crossing counts only when the new polarity has been seen on two samples in a row. The number of sample ticks between two accepted crossings is one half-period. That count is kept in a hold register until the next crossing replaces it.

The held half-period is compared with six precomputed count limits. Three limits are for frequencies above nominal and three are for frequencies below it. The result is a deviation band of more than 0.5 Hz, more than 1 Hz or more than 1.5 Hz away from nominal. No reciprocal is computed.

A band that stays out of range in one direction for a qualifying number of ticks releases a shed code: 33 %, 66 % or 100 % of the load. A direction bit reports whether the excursion is high or low. A deviation shorter than the qualifying time has no effect. The qualifying time is 5 s of samples by default and can be set to any value.

Top module: `freq_shed_ctrl`

## Requirements
- R1: After reset, shed_level = 0, shed_over = 0, period_valid = 0 and half_period = 0.
- R2: A crossing is accepted only when line_sign differs from the last accepted polarity on two consecutive ticks. A polarity that lasts a single tick is ignored.
- R3: half_period equals the number of sample ticks from one accepted crossing to the next. It holds that value until the next crossing. period_valid goes high at the second accepted crossing after reset and stays high. Neither changes, and the persistence timer does not advance, in cycles where sample_tick is low.
- R4: Over-frequency band k (k = 1, 2, 3 for more than 0.5, 1 and 1.5 Hz above nominal) is hit when half_period × (2·NOM_HZ + k) < SAMPLE_HZ. The highest band hit is the one reported.
- R5: Under-frequency band k (k = 1, 2, 3 for more than 0.5, 1 and 1.5 Hz below nominal) is hit when half_period × (2·NOM_HZ − k) > SAMPLE_HZ. The highest band hit is the one reported.
- R6: When no band is hit (deviation of 0.5 Hz or less), shed_level is 0.
- R7: shed_level stays 0 until a nonzero band in one direction has lasted QUAL_TICKS ticks. An excursion shorter than that leaves shed_level at 0.
- R8: Once qualified, the shed code follows the band: 0 = none, 1 = 33 %, 2 = 66 %, 3 = 100 %. shed_over is 1 for over-frequency and 0 for under-frequency, and it is 1 only while shed_level is nonzero. A return to the deadband clears shed_level at once.
- R9: A change of direction restarts the persistence timer, so shed_level is 0 until the new direction has lasted QUAL_TICKS ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_tick | input | 1 | One pulse per voltage sample |
| line_sign | input | 1 | Polarity of the sampled voltage, 1 = positive |
| shed_level | output | 2 | Shed code: 0 none, 1 33 %, 2 66 %, 3 100 % |
| shed_over | output | 1 | 1 when the shed is for over-frequency |
| half_period | output | HALF_W | Held tick count between the last two crossings |
| period_valid | output | 1 | half_period holds a complete measurement |

## Verification
The assertions check several rules on every cycle:
- the shed code agrees with the held half-period: an over-frequency shed implies a count at or below the first over limit, an under-frequency shed implies a count at or above the first under limit, and a deadband count implies no shed;
- the hold register does not move without a tick;
- period_valid never falls;
- a shed starts only on a tick.

Only the bench scenarios can show the following: that a single-tick glitch is rejected, that the band edges fall at the stated frequencies, that a short excursion is ignored, that qualification waits the full tick count, and that a direction reversal restarts that wait.

// File: rtl/freq_shed_pkg.sv
package freq_shed_pkg;

  typedef enum logic [1:0] {
    SHED_NONE = 2'd0,
    SHED_33   = 2'd1,
    SHED_66   = 2'd2,
    SHED_ALL  = 2'd3
  } shed_e;

  localparam int NBANDS = 3;

  // Largest half-period count h with h * (2*nom + k) < s.
  function automatic int over_limit(input int s, input int nom, input int k);
    return (s - 1) / (2 * nom + k);
  endfunction

  // Smallest half-period count h with h * (2*nom - k) > s.
  function automatic int under_limit(input int s, input int nom, input int k);
    return s / (2 * nom - k) + 1;
  endfunction

endpackage

// File: rtl/freq_zc_detect.sv
module freq_zc_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic sign_in,
  output logic xing
);

  logic prev_q, prev_d;
  logic pol_q, pol_d;

  // A crossing needs the new polarity on this sample and on the one before.
  assign xing = tick && (sign_in != pol_q) && (prev_q == sign_in);

  always_comb begin
    prev_d = prev_q;
    pol_d  = pol_q;
    if (tick) begin
      prev_d = sign_in;
      if (xing) pol_d = sign_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      pol_q  <= 1'b0;
    end else begin
      prev_q <= prev_d;
      pol_q  <= pol_d;
    end
  end

endmodule

// File: rtl/freq_interval.sv
module freq_interval #(
  parameter int HALF_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              xing,
  output logic [HALF_W-1:0] half_q,
  output logic              valid_q
);

  localparam logic [HALF_W-1:0] CNT_MAX = '1;

  logic [HALF_W-1:0] cnt_q, cnt_d, half_d, cnt_inc;
  logic              seen_q, seen_d, valid_d;

  assign cnt_inc = (cnt_q == CNT_MAX) ? CNT_MAX : cnt_q + 1'b1;

  always_comb begin
    cnt_d   = cnt_q;
    half_d  = half_q;
    seen_d  = seen_q;
    valid_d = valid_q;
    if (tick) begin
      if (xing) begin
        half_d  = cnt_inc;
        cnt_d   = '0;
        seen_d  = 1'b1;
        valid_d = valid_q | seen_q;
      end else begin
        cnt_d = cnt_inc;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      half_q  <= '0;
      seen_q  <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      half_q  <= half_d;
      seen_q  <= seen_d;
      valid_q <= valid_d;
    end
  end

endmodule

// File: rtl/freq_band_class.sv
module freq_band_class
  import freq_shed_pkg::*;
#(
  parameter int HALF_W    = 10,
  parameter int SAMPLE_HZ = 20000,
  parameter int NOM_HZ    = 50
) (
  input  logic [HALF_W-1:0] half,
  input  logic              valid,
  output shed_e             band,
  output logic              over
);

  logic [NBANDS:1] ov_hit;
  logic [NBANDS:1] un_hit;

  for (genvar k = 1; k <= NBANDS; k++) begin : g_lim
    localparam int OL = over_limit(SAMPLE_HZ, NOM_HZ, k);
    localparam int UL = under_limit(SAMPLE_HZ, NOM_HZ, k);
    assign ov_hit[k] = valid && (half <= HALF_W'(OL));
    assign un_hit[k] = valid && (half >= HALF_W'(UL));
  end

  always_comb begin
    band = SHED_NONE;
    over = 1'b0;
    for (int k = 1; k <= NBANDS; k++) begin
      if (ov_hit[k]) begin
        band = shed_e'(2'(k));
        over = 1'b1;
      end else if (un_hit[k]) begin
        band = shed_e'(2'(k));
        over = 1'b0;
      end
    end
  end

endmodule

// File: rtl/freq_persist.sv
module freq_persist
  import freq_shed_pkg::*;
#(
  parameter int QUAL_TICKS = 1000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  shed_e      band,
  input  logic       over,
  output logic [1:0] level,
  output logic       level_over
);

  localparam int TW = $clog2(QUAL_TICKS + 1);
  localparam logic [TW-1:0] QUAL = TW'(QUAL_TICKS);

  logic [TW-1:0] timer_q, timer_d;
  logic          dir_q, dir_d;
  logic          qualified;

  always_comb begin
    timer_d = timer_q;
    dir_d   = dir_q;
    if (band == SHED_NONE) begin
      timer_d = '0;
    end else if (over != dir_q) begin
      timer_d = '0;
      dir_d   = over;
    end else if (tick && (timer_q != QUAL)) begin
      timer_d = timer_q + 1'b1;
    end
  end

  assign qualified  = (band != SHED_NONE) && (over == dir_q) && (timer_q == QUAL);
  assign level      = qualified ? band : SHED_NONE;
  assign level_over = qualified && over;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      timer_q <= '0;
      dir_q   <= 1'b0;
    end else begin
      timer_q <= timer_d;
      dir_q   <= dir_d;
    end
  end

endmodule

// File: rtl/freq_shed_ctrl.sv
module freq_shed_ctrl
  import freq_shed_pkg::*;
#(
  parameter int SAMPLE_HZ  = 20000,
  parameter int NOM_HZ     = 50,
  parameter int QUAL_TICKS = 5 * SAMPLE_HZ,
  parameter int HALF_W     = $clog2(4 * SAMPLE_HZ / (2 * NOM_HZ) + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample_tick,
  input  logic              line_sign,
  output logic [1:0]        shed_level,
  output logic              shed_over,
  output logic [HALF_W-1:0] half_period,
  output logic              period_valid
);

  logic [1:0] rst_pipe;
  logic       core_rst_n;
  logic       xing;
  shed_e      band;
  logic       band_over;

  // Reset asserts at once and leaves on a clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign core_rst_n = rst_pipe[1];

  freq_zc_detect u_zc (
    .clk     (clk),
    .rst_n   (core_rst_n),
    .tick    (sample_tick),
    .sign_in (line_sign),
    .xing    (xing)
  );

  freq_interval #(.HALF_W(HALF_W)) u_iv (
    .clk     (clk),
    .rst_n   (core_rst_n),
    .tick    (sample_tick),
    .xing    (xing),
    .half_q  (half_period),
    .valid_q (period_valid)
  );

  freq_band_class #(.HALF_W(HALF_W), .SAMPLE_HZ(SAMPLE_HZ), .NOM_HZ(NOM_HZ)) u_cls (
    .half  (half_period),
    .valid (period_valid),
    .band  (band),
    .over  (band_over)
  );

  freq_persist #(.QUAL_TICKS(QUAL_TICKS)) u_per (
    .clk        (clk),
    .rst_n      (core_rst_n),
    .tick       (sample_tick),
    .band       (band),
    .over       (band_over),
    .level      (shed_level),
    .level_over (shed_over)
  );

endmodule

// File: rtl/freq_shed_chk.sv
module freq_shed_chk
  import freq_shed_pkg::*;
#(
  parameter int HALF_W    = 10,
  parameter int SAMPLE_HZ = 20000,
  parameter int NOM_HZ    = 50
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sample_tick,
  input logic [1:0]        shed_level,
  input logic              shed_over,
  input logic [HALF_W-1:0] half_period,
  input logic              period_valid
);

  localparam logic [HALF_W-1:0] OVR1 = HALF_W'(over_limit(SAMPLE_HZ, NOM_HZ, 1));
  localparam logic [HALF_W-1:0] UND1 = HALF_W'(under_limit(SAMPLE_HZ, NOM_HZ, 1));

  AST_OVER_NEEDS_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
    shed_over |-> (shed_level != 2'd0) && (half_period <= OVR1)); // R4

  AST_UNDER_NEEDS_LONG: assert property (@(posedge clk) disable iff (!rst_n)
    ((shed_level != 2'd0) && !shed_over) |-> (half_period >= UND1)); // R5

  AST_DEADBAND_NO_SHED: assert property (@(posedge clk) disable iff (!rst_n)
    (period_valid && (half_period > OVR1) && (half_period < UND1)) |-> (shed_level == 2'd0)); // R6

  AST_SHED_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (shed_level != 2'd0) |-> period_valid); // R7

  AST_SHED_STARTS_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(shed_level != 2'd0) |-> $past(sample_tick)); // R7

  AST_HOLD_WITHOUT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_tick |=> $stable(half_period)); // R3

  AST_VALID_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    period_valid |=> period_valid); // R3

endmodule

bind freq_shed_ctrl freq_shed_chk #(
  .HALF_W(HALF_W), .SAMPLE_HZ(SAMPLE_HZ), .NOM_HZ(NOM_HZ)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .sample_tick  (sample_tick),
  .shed_level   (shed_level),
  .shed_over    (shed_over),
  .half_period  (half_period),
  .period_valid (period_valid)
);

// File: tb/freq_shed_ctrl_test.sv
module freq_shed_ctrl_test;

  localparam int S    = 20000;
  localparam int NOM  = 50;
  localparam int QUAL = 1000;
  localparam int HW   = $clog2(4 * S / (2 * NOM) + 1);
  localparam int NV   = 12;
  // Each row: half-period in ticks, expected shed code, expected over bit.
  // 200 ticks is 50 Hz; the limits are 198/196/194 above and 203/205/207 below nominal.
  localparam int VEC [NV][3] = '{
    '{200, 0, 0}, '{199, 0, 0}, '{198, 1, 1}, '{196, 2, 1},
    '{194, 3, 1}, '{190, 3, 1}, '{202, 0, 0}, '{203, 1, 0},
    '{205, 2, 0}, '{207, 3, 0}, '{215, 3, 0}, '{197, 1, 1}
  };

  logic          clk;
  logic          rst_n;
  logic          sample_tick;
  logic          line_sign;
  logic [1:0]    shed_level;
  logic          shed_over;
  logic [HW-1:0] half_period;
  logic          period_valid;

  int checks;
  int fails;
  int ph;
  int cyc;

  freq_shed_ctrl #(.SAMPLE_HZ(S), .NOM_HZ(NOM), .QUAL_TICKS(QUAL)) uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .sample_tick  (sample_tick),
    .line_sign    (line_sign),
    .shed_level   (shed_level),
    .shed_over    (shed_over),
    .half_period  (half_period),
    .period_valid (period_valid)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  initial begin
    cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 190000) begin
        fails++;
        checks++;
        $display("FAIL watchdog: run did not finish, got %0d cycles, expected under 190000", cyc);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Toggle the sign every n ticks, for a given number of cycles.
  task automatic run(input int n, input int cycles);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      ph++;
      if (ph >= n) begin
        line_sign = ~line_sign;
        ph = 0;
      end
    end
  endtask

  task automatic idle(input int cycles);
    for (int i = 0; i < cycles; i++) @(negedge clk);
  endtask

  initial begin
    checks      = 0;
    fails       = 0;
    ph          = 0;
    rst_n       = 1'b0;
    sample_tick = 1'b1;
    line_sign   = 1'b0;
    idle(5);
    check("R1 shed_level after reset", shed_level, 0);
    check("R1 shed_over after reset", shed_over, 0);
    check("R1 period_valid after reset", period_valid, 0);
    check("R1 half_period after reset", half_period, 0);
    rst_n = 1'b1;
    idle(4);

    run(200, 1500);
    check("R3 valid after crossings", period_valid, 1);
    check("R3 half_period nominal", half_period, 200);
    check("R6 nominal no shed", shed_level, 0);

    for (int v = 0; v < NV; v++) begin
      run(VEC[v][0], QUAL + 3 * VEC[v][0] + 50);
      check($sformatf("R3 half_period vec %0d", v), half_period, VEC[v][0]);
      check($sformatf("R4 R5 R6 R8 shed_level vec %0d", v), shed_level, VEC[v][1]);
      check($sformatf("R8 shed_over vec %0d", v), shed_over, VEC[v][2]);
    end

    // R3: ticks stop, so nothing moves.
    sample_tick = 1'b0;
    idle(300);
    check("R3 hold half_period without tick", half_period, 197);
    check("R3 hold shed without tick", shed_level, 1);
    sample_tick = 1'b1;

    run(200, 1500);
    check("R8 back to deadband clears shed", shed_level, 0);
    check("R8 over bit clear with shed", shed_over, 0);

    // R2: a polarity that lasts one tick is not a crossing.
    while (ph != 100) run(200, 1);
    @(negedge clk);
    ph++;
    line_sign = ~line_sign;
    @(negedge clk);
    ph++;
    line_sign = ~line_sign;
    run(200, 3);
    check("R2 glitch ignored, half_period kept", half_period, 200);
    run(200, 400);
    check("R2 interval after glitch", half_period, 200);

    // R7: an excursion shorter than the qualifying time.
    run(194, 600);
    check("R7 short excursion no shed (during)", shed_level, 0);
    run(200, 1500);
    check("R7 short excursion no shed (after)", shed_level, 0);

    // R7: the qualifying time is waited in full.
    run(194, QUAL - 10);
    check("R7 no shed before qualifying time", shed_level, 0);
    run(194, 2 * 194 + 40);
    check("R7 shed after qualifying time", shed_level, 3);
    check("R7 over bit after qualifying", shed_over, 1);

    // R9: a reversal of direction restarts the wait.
    run(215, 2 * 215 + 10);
    check("R9 reversal clears shed", shed_level, 0);
    run(215, QUAL + 50);
    check("R9 under shed after new wait", shed_level, 3);
    check("R9 under direction bit", shed_over, 0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule